// File: doc/BRIEF.md
# Frame Length Statistics Counters

This block keeps a bank of 32-bit event counters for an Ethernet-style MAC, one half for the transmit path and one half for the receive path. Each time a frame finishes, the datapath raises a one-cycle strobe together with the frame's byte count and a direction bit. For that direction the block then updates five counters together:

- the packet total;
- the octet total;
- one bin of a fixed length histogram;
- the frame-OK total;
- the OK-octets total.

The caller supplies the length it wants counted. On the transmit side this is the gathered length after truncation. On the receive side it is the length including the four trailing CRC bytes.

Software sees all counters as one 64-word space. A 6-bit word index selects a word, and each word sits at a 4-byte step above the counter window base in the host's register map. A read returns the selected word at once. A write loads the selected word. The error counters (collisions, CRC and alignment errors, and similar) are plain read/write words that this block never changes. Word indices that carry no counter read as zero.

Control is a two-state machine:

- `ST_IDLE`: no captured frame is waiting.
- `ST_COMMIT`: a captured frame is applied to the bank in this cycle.

Transitions:

- `IDLE->COMMIT` on a strobe.
- `COMMIT->COMMIT` on a strobe in the commit cycle, so back-to-back frames are all counted.
- `COMMIT->IDLE` with no strobe.
- `IDLE->IDLE` with no strobe.

Top module: `fstat_unit`

## Requirements
- R1: After reset every word of the 64-word space reads zero.
- R2: Each frame adds one to the packet counter of its direction. The packet counter is word 1 for transmit (`frm_dir`=0) and word 33 for receive (`frm_dir`=1). Counters of the other direction are left unchanged.
- R3: Each frame adds its length to the octet counter of its direction, word 17 (transmit) or word 49 (receive). The addition wraps modulo 2^32.
- R4: Each frame adds one to exactly one histogram bin of its direction. Transmit bins, by length:
  - below 64: word 7
  - exactly 64: word 10
  - 65-127: word 11
  - 128-255: word 12
  - 256-511: word 13
  - 512-1023: word 14
  - 1024-2047: word 15
  - 2048 and above: word 16

  Receive bins are the same length ranges at words 39, 42, 43, 44, 45, 46, 47 and 48, in that order.
- R5: Each frame adds one to the frame-OK counter (word 19 transmit, word 51 receive). It also adds its length, modulo 2^32, to the OK-octets counter (word 29 transmit, word 56 receive).
- R6: A strobe sampled at one rising edge is visible in the counters after the next rising edge. Strobes on consecutive cycles are all counted.
- R7: `sw_rdata` combinationally shows the word selected by `sw_addr`. A write (`sw_wr`=1) to a live word loads `sw_wdata` at the rising edge.
- R8: When a software write and a frame update target the same word in the same cycle, the written value is kept. Other words touched by that update still update.
- R9: Words 30, 31 and 57 to 63 always read zero, and writes to them are ignored.
- R10: Live words that no frame updates (error counters) hold whatever software wrote, whatever frames pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle frame-completion strobe |
| frm_dir | input | 1 | Direction: 0 transmit, 1 receive |
| frm_len | input | 16 | Frame length in bytes to be counted |
| sw_addr | input | 6 | Counter word index for software access |
| sw_wr | input | 1 | Software write enable |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Selected counter word |

## Verification
Every cycle, the checker enforces the following:
- A strobe is followed by a commit cycle, and no commit happens without one.
- A commit touches exactly five words.
- Unmapped indices read zero.
- A software write shows up unchanged on the next cycle, even when a commit landed on the same word.
- With no commit and no write, the selected word holds still.

Only the bench's scenarios can show the rest:
- each word's index and increment is correct;
- the histogram boundaries fall at the right lengths;
- the octet totals wrap modulo 2^32;
- back-to-back frames are both counted.

The bench checks these by sweeping boundary lengths in both directions against an arithmetic model of the whole word space.

// File: rtl/fstat_pkg.sv
package fstat_pkg;

    localparam int CNT_W   = 32;
    localparam int LEN_W   = 16;
    localparam int N_WORDS = 64;
    localparam int ADDR_W  = $clog2(N_WORDS);
    localparam int N_BINS  = 8;
    localparam int BIN_W   = $clog2(N_BINS);

    // Word layout of the counter space (decoded by software).
    localparam int TX_BASE     = 0;
    localparam int RX_BASE     = 32;
    localparam int TX_LAST     = 29;
    localparam int RX_LAST     = 56;
    localparam int OFS_PKT     = 1;
    localparam int OFS_SMALL   = 7;
    localparam int OFS_HIST64  = 10;
    localparam int OFS_OCT     = 17;
    localparam int OFS_OK      = 19;
    localparam int TX_OK_OCT   = 29;
    localparam int RX_OK_OCT   = 56;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } fstat_state_e;

    function automatic logic word_live(input logic [ADDR_W-1:0] idx);
        return (int'(idx) >= TX_BASE && int'(idx) <= TX_LAST) ||
               (int'(idx) >= RX_BASE && int'(idx) <= RX_LAST);
    endfunction

    function automatic int dir_base(input logic dir);
        return dir ? RX_BASE : TX_BASE;
    endfunction

    function automatic int hist_word(input logic dir, input logic [BIN_W-1:0] bin);
        if (bin == '0) return dir_base(dir) + OFS_SMALL;
        return dir_base(dir) + OFS_HIST64 + int'(bin) - 1;
    endfunction

    function automatic int ok_oct_word(input logic dir);
        return dir ? RX_OK_OCT : TX_OK_OCT;
    endfunction

endpackage

// File: rtl/fstat_binner.sv
module fstat_binner
    import fstat_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    output logic [BIN_W-1:0] bin
);
    localparam int MIN_LEN = 64;
    localparam int N_STEPS = N_BINS - 2;

    always_comb begin
        logic [BIN_W-1:0] steps;
        steps = '0;
        for (int k = 1; k <= N_STEPS - 1; k++) begin
            if (int'(len) >= (MIN_LEN << k)) steps = steps + 1'b1;
        end
        if (int'(len) < MIN_LEN)
            bin = '0;
        else if (int'(len) == MIN_LEN)
            bin = BIN_W'(1);
        else
            bin = BIN_W'(2) + steps;
    end
endmodule

// File: rtl/fstat_ctrl.sv
module fstat_ctrl
    import fstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_valid,
    input  logic             frm_dir,
    input  logic [LEN_W-1:0] frm_len,
    output logic             upd_en,
    output logic             upd_dir,
    output logic [LEN_W-1:0] upd_len
);
    fstat_state_e state_q, state_d;
    logic             dir_q;
    logic [LEN_W-1:0] len_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = frm_valid ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = frm_valid ? ST_COMMIT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            if (frm_valid) begin
                dir_q <= frm_dir;
                len_q <= frm_len;
            end
        end
    end

    always_comb begin
        upd_en  = 1'b0;
        upd_dir = dir_q;
        upd_len = len_q;
        unique case (state_q)
            ST_IDLE:   upd_en = 1'b0;
            ST_COMMIT: upd_en = 1'b1;
            default:   upd_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/fstat_bank.sv
module fstat_bank
    import fstat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic [N_WORDS-1:0] inc_mask,
    input  logic [N_WORDS-1:0] oct_mask,
    input  logic [LEN_W-1:0]   upd_len,
    input  logic [ADDR_W-1:0]  sw_addr,
    input  logic               sw_wr,
    input  logic [CNT_W-1:0]   sw_wdata,
    output logic [CNT_W-1:0]   sw_rdata
);
    logic [CNT_W-1:0] word_q [N_WORDS];

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        if (word_live(ADDR_W'(i))) begin : g_live
            logic [CNT_W-1:0] step;
            logic             hit_wr;
            assign step   = oct_mask[i] ? CNT_W'(upd_len) : CNT_W'(1);
            assign hit_wr = sw_wr && (sw_addr == ADDR_W'(i));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    word_q[i] <= '0;
                else if (hit_wr)
                    word_q[i] <= sw_wdata;
                else if (upd_en && inc_mask[i])
                    word_q[i] <= word_q[i] + step;
            end
        end else begin : g_dead
            assign word_q[i] = '0;
        end
    end

    assign sw_rdata = word_q[sw_addr];
endmodule

// File: rtl/fstat_unit.sv
module fstat_unit
    import fstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              frm_dir,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic              sw_wr,
    input  logic [CNT_W-1:0]  sw_wdata,
    output logic [CNT_W-1:0]  sw_rdata
);
    logic               upd_en;
    logic               upd_dir;
    logic [LEN_W-1:0]   upd_len;
    logic [BIN_W-1:0]   upd_bin;
    logic [N_WORDS-1:0] inc_mask;
    logic [N_WORDS-1:0] oct_mask;

    fstat_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_dir   (frm_dir),
        .frm_len   (frm_len),
        .upd_en    (upd_en),
        .upd_dir   (upd_dir),
        .upd_len   (upd_len)
    );

    fstat_binner u_binner (
        .len (upd_len),
        .bin (upd_bin)
    );

    always_comb begin
        inc_mask = '0;
        oct_mask = '0;
        inc_mask[dir_base(upd_dir) + OFS_PKT]  = 1'b1;
        inc_mask[dir_base(upd_dir) + OFS_OCT]  = 1'b1;
        inc_mask[dir_base(upd_dir) + OFS_OK]   = 1'b1;
        inc_mask[ok_oct_word(upd_dir)]         = 1'b1;
        inc_mask[hist_word(upd_dir, upd_bin)]  = 1'b1;
        oct_mask[dir_base(upd_dir) + OFS_OCT]  = 1'b1;
        oct_mask[ok_oct_word(upd_dir)]         = 1'b1;
    end

    fstat_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .inc_mask (inc_mask),
        .oct_mask (oct_mask),
        .upd_len  (upd_len),
        .sw_addr  (sw_addr),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .sw_rdata (sw_rdata)
    );
endmodule

// File: rtl/fstat_checker.sv
module fstat_checker
    import fstat_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               frm_valid,
    input logic [ADDR_W-1:0]  sw_addr,
    input logic               sw_wr,
    input logic [CNT_W-1:0]   sw_wdata,
    input logic [CNT_W-1:0]   sw_rdata,
    input logic               upd_en,
    input logic [N_WORDS-1:0] inc_mask
);
    p_commit_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> upd_en);

    p_no_spurious_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !upd_en);

    p_five_targets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> ($countones(inc_mask) == 5));

    p_dead_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !word_live(sw_addr) |-> (sw_rdata == '0));

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && word_live(sw_addr)) |=>
            (!$stable(sw_addr) || sw_rdata == $past(sw_wdata)));

    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !sw_wr) |=> (!$stable(sw_addr) || $stable(sw_rdata)));
endmodule

bind fstat_unit fstat_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_valid(frm_valid),
    .sw_addr  (sw_addr),
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .sw_rdata (sw_rdata),
    .upd_en   (upd_en),
    .inc_mask (inc_mask)
);

// File: tb/fstat_unit_bench.sv
module fstat_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic        frm_dir = 1'b0;
    logic [15:0] frm_len = '0;
    logic [5:0]  sw_addr = '0;
    logic        sw_wr = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    logic [31:0] model [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    fstat_unit u_fstat_unit (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_dir(frm_dir),
        .frm_len(frm_len), .sw_addr(sw_addr), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
    );

    function automatic bit live(input int i);
        return (i <= 29) || (i >= 32 && i <= 56);
    endfunction

    function automatic int bin_word(input bit dir, input int len);
        int b;
        if (len < 64) b = dir ? 39 : 7;
        else if (len == 64) b = dir ? 42 : 10;
        else if (len < 128) b = dir ? 43 : 11;
        else if (len < 256) b = dir ? 44 : 12;
        else if (len < 512) b = dir ? 45 : 13;
        else if (len < 1024) b = dir ? 46 : 14;
        else if (len < 2048) b = dir ? 47 : 15;
        else b = dir ? 48 : 16;
        return b;
    endfunction

    task automatic model_frame(input bit dir, input int len);
        int base = dir ? 32 : 0;
        model[base + 1]  = model[base + 1] + 1;
        model[base + 17] = model[base + 17] + 32'(len);
        model[base + 19] = model[base + 19] + 1;
        model[dir ? 56 : 29] = model[dir ? 56 : 29] + 32'(len);
        model[bin_word(dir, len)] = model[bin_word(dir, len)] + 1;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 64; i++) begin
            sw_addr = 6'(i);
            #1;
            n_checks++;
            if (sw_rdata !== model[i]) begin
                n_errors++;
                $display("FAIL %s word %0d actual=%h expected=%h", tag, i, sw_rdata, model[i]);
            end
        end
    endtask

    // R6: strobe at edge k, counters updated after edge k+1.
    task automatic send(input bit dir, input int len);
        @(negedge clk);
        frm_valid = 1'b1; frm_dir = dir; frm_len = 16'(len);
        @(negedge clk);
        frm_valid = 1'b0;
        @(negedge clk);
        model_frame(dir, len);
    endtask

    task automatic sw_write(input int idx, input logic [31:0] val);
        @(negedge clk);
        sw_wr = 1'b1; sw_addr = 6'(idx); sw_wdata = val;
        @(negedge clk);
        sw_wr = 1'b0;
        if (live(idx)) model[idx] = val;
    endtask

    int lens [15] = '{0, 1, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047, 2048};

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2 R3 R4 R5: boundary sweep in both directions
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 15; k++) begin
                send(d[0], lens[k]);
                check_all(d == 0 ? "R2 R4 R5 tx sweep" : "R2 R4 R5 rx sweep");
            end
        end
        send(1'b0, 65535);
        check_all("R4 tx max length");

        // R6: back-to-back strobes, different directions
        @(negedge clk);
        frm_valid = 1'b1; frm_dir = 1'b0; frm_len = 16'd100;
        @(negedge clk);
        frm_dir = 1'b1; frm_len = 16'd3000;
        @(negedge clk);
        frm_valid = 1'b0;
        @(negedge clk);
        model_frame(1'b0, 100);
        model_frame(1'b1, 3000);
        check_all("R6 back-to-back");

        // R3 R5: octet wrap
        sw_write(17, 32'hFFFF_FFF0);
        sw_write(56, 32'hFFFF_FFFF);
        send(1'b0, 32);
        send(1'b1, 2);
        check_all("R3 R5 wrap");

        // R8: write collides with commit on same word
        @(negedge clk);
        frm_valid = 1'b1; frm_dir = 1'b0; frm_len = 16'd200;
        @(negedge clk);
        frm_valid = 1'b0;
        sw_wr = 1'b1; sw_addr = 6'd1; sw_wdata = 32'h0000_ABCD;
        @(negedge clk);
        sw_wr = 1'b0;
        model_frame(1'b0, 200);
        model[1] = 32'h0000_ABCD;
        check_all("R8 write priority");

        // R7 R9 R10: write every word, then frames leave error words alone
        for (int i = 0; i < 64; i++) sw_write(i, 32'h5A00_0000 + 32'(i));
        check_all("R7 R9 write all");
        send(1'b0, 700);
        send(1'b1, 64);
        check_all("R10 error words hold");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule